// File: doc/BRIEF.md
# Protected Control Register Write Sequencer

This block models the configuration register of a supply supervisor. The register holds a watchdog-period select, a power-up-delay select and a block-protect enable. Software may change these only through a fixed unlock sequence of three separate write transactions. The first arms a volatile write-enable latch. The second arms a second, register-level enable latch. The third carries the new configuration image and starts a commit of fixed length, during which the block reports busy.

The block is driven by an abstract byte-transaction interface. Each transaction is framed by start and stop strobes. Each data byte arrives with its position inside the transaction, a flag saying whether it targets this register or the array behind it, and a flag marking a write to a protected area. Every data byte gets exactly one registered ack or nack. Each register write is held until its stop strobe and takes effect there, so a transaction that carries an extra byte is dropped. Read strobes pass through without touching the sequence.

Top module: `prot_ctlreg_seq`

## Requirements
- R1: After reset, both enable latches are clear, busy is low, ack and nack are low, and the watchdog, power-up and protect outputs are all zero.
- R2: While the write-enable latch is clear, a first register data byte is acked only when it equals 02h, and an array data byte is nacked. A nacked byte changes no state.
- R3: An acked register byte of 02h sets the write-enable latch and one of 00h clears it, both at stop. Neither raises busy.
- R4: A register byte of 06h, written while the write-enable latch is set and the register-enable latch is clear, sets the register-enable latch at stop.
- R5: With both latches set, a register byte whose bits [3:1] equal 001 starts a commit. Busy is high for exactly COMMIT_CYCLES cycles, starting the cycle after stop. When busy falls, the power-up select becomes {bit7, bit0}, the watchdog select becomes bits [6:5] and the protect enable becomes bit 4. The register-enable latch is cleared and the write-enable latch stays set. 02h therefore commits all zeros.
- R6: With both latches set, a register byte whose bits [3:1] equal 011 (for example 06h) is acked, raises no busy, keeps the register-enable latch set and leaves the configuration unchanged.
- R7: Any other acked register byte that matches no step leaves both latches and the configuration unchanged.
- R8: A register data byte at a nonzero position inside a transaction is nacked. The held first byte of that transaction is discarded, so nothing changes at stop.
- R9: While busy is high, every data byte is nacked and has no effect.
- R10: Read strobes between the unlock steps do not disturb the latches or the sequence.
- R11: An array byte flagged as protected is nacked and clears the register-enable latch, leaving the write-enable latch as it was. An unprotected array byte is acked when the write-enable latch is set and the block is idle.
- R12: Ack and nack are never high together. Exactly one of them is high in the cycle after a byte strobe, and neither is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Transaction start strobe |
| txn_stop | input | 1 | Transaction stop strobe |
| rd_strobe | input | 1 | Read transaction strobe (no effect on state) |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte value |
| byte_pos | input | POS_W | Position of the byte inside its transaction, 0 for the first |
| byte_to_reg | input | 1 | 1 when the byte targets this register, 0 for the array |
| byte_prot | input | 1 | Array byte targets a protected area |
| byte_ack | output | 1 | Registered acknowledge for the previous byte |
| byte_nack | output | 1 | Registered refusal for the previous byte |
| busy | output | 1 | Commit in progress |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-enable latch |
| wd_sel | output | 2 | Watchdog period select |
| pup_sel | output | 2 | Power-up delay select |
| bp_en | output | 1 | Block-protect enable |

## Verification
The assertions assume that the host raises at most one of start, stop and the byte strobe in any cycle. They also assume that a register data byte arrives only between a start and its stop, and that no commit starts while busy is high. The bench drives each strobe for exactly one cycle from a task and leaves idle cycles between strobes. It waits for busy to fall before starting a new unlock sequence, except in the one case that deliberately sends bytes during a commit to check that they are refused.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam logic [7:0] CMD_WEL_SET  = 8'h02;
  localparam logic [7:0] CMD_WEL_CLR  = 8'h00;
  localparam logic [7:0] CMD_RWEL_SET = 8'h06;
  localparam logic [2:0] PAT_COMMIT   = 3'b001;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WEL,
    OP_CLR_WEL,
    OP_SET_RWEL,
    OP_COMMIT
  } op_e;

  typedef struct packed {
    logic [1:0] pup;
    logic [1:0] wd;
    logic       bp;
  } cfg_t;

  // Decide what an accepted register byte does, given the two latches.
  function automatic op_e classify(input logic [7:0] b, input logic wel, input logic rwel);
    op_e op;
    op = OP_NONE;
    if (b == CMD_WEL_CLR) begin
      op = wel ? OP_CLR_WEL : OP_NONE;
    end else if (!wel) begin
      op = (b == CMD_WEL_SET) ? OP_SET_WEL : OP_NONE;
    end else if (!rwel) begin
      op = (b == CMD_RWEL_SET) ? OP_SET_RWEL : OP_NONE;
    end else if (b[3:1] == PAT_COMMIT) begin
      op = OP_COMMIT;
    end
    return op;
  endfunction

  // Third-step byte image to configuration fields.
  function automatic cfg_t unpack_cfg(input logic [7:0] b);
    cfg_t c;
    c.pup = {b[7], b[0]};
    c.wd  = b[6:5];
    c.bp  = b[4];
    return c;
  endfunction

endpackage

// File: rtl/ctlreg_txn.sv
module ctlreg_txn
  import ctlreg_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic             txn_stop,
  input  logic             rd_strobe,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic [POS_W-1:0] byte_pos,
  input  logic             byte_to_reg,
  input  logic             byte_prot,
  input  logic             wel,
  input  logic             busy,
  output logic             byte_ack,
  output logic             byte_nack,
  output logic             apply_v,
  output logic [7:0]       apply_b,
  output logic             prot_clr
);

  logic       pend_v;
  logic [7:0] pend_b;
  logic       accept;
  logic       first_pos;

  assign first_pos = (byte_pos == '0);

  always_comb begin
    accept = 1'b0;
    if (byte_to_reg) begin
      accept = first_pos && !busy && (wel || byte_data == CMD_WEL_SET);
    end else begin
      accept = wel && !busy && !byte_prot;
    end
  end

  assign apply_v  = txn_stop && pend_v;
  assign apply_b  = pend_b;
  assign prot_clr = byte_valid && !byte_to_reg && byte_prot;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_b    <= '0;
      byte_ack  <= 1'b0;
      byte_nack <= 1'b0;
    end else begin
      byte_ack  <= byte_valid && accept;
      byte_nack <= byte_valid && !accept;
      if (txn_start || txn_stop) begin
        pend_v <= 1'b0;
      end else if (byte_valid && byte_to_reg) begin
        if (accept) begin
          pend_v <= 1'b1;
          pend_b <= byte_data;
        end else if (!first_pos) begin
          pend_v <= 1'b0;
        end
      end
    end
  end

  p_ack_nack_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(byte_ack && byte_nack));
  p_resp_after_valid_r12: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> (byte_ack || byte_nack));
  p_no_resp_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> !(byte_ack || byte_nack));
  p_busy_nack_r9: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && busy) |=> byte_nack);
  p_second_byte_nack_r8: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_to_reg && !first_pos) |=> (byte_nack && !pend_v));
  p_read_inert_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !byte_valid && !txn_start && !txn_stop) |=> $stable(pend_v));

endmodule

// File: rtl/ctlreg_timer.sv
module ctlreg_timer #(
  parameter int COMMIT_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(COMMIT_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= LOAD;
      busy <= 1'b1;
    end else if (busy) begin
      cnt  <= cnt - ONE;
      busy <= (cnt != ONE);
    end
  end

  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  p_done_ends_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

endmodule

// File: rtl/ctlreg_latches.sv
module ctlreg_latches
  import ctlreg_pkg::*;
#(
  parameter logic [7:0] RESET_IMAGE = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       apply_v,
  input  logic [7:0] apply_b,
  input  logic       prot_clr,
  input  logic       done,
  output logic       commit_go,
  output logic       wel_q,
  output logic       rwel_q,
  output cfg_t       cfg_q
);

  op_e        op;
  logic [7:0] stage_q;

  assign op        = classify(apply_b, wel_q, rwel_q);
  assign commit_go = apply_v && (op == OP_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q   <= 1'b0;
      rwel_q  <= 1'b0;
      stage_q <= '0;
      cfg_q   <= unpack_cfg(RESET_IMAGE);
    end else begin
      if (done) begin
        cfg_q  <= unpack_cfg(stage_q);
        rwel_q <= 1'b0;
      end
      if (apply_v) begin
        case (op)
          OP_SET_WEL:  wel_q  <= 1'b1;
          OP_CLR_WEL:  wel_q  <= 1'b0;
          OP_SET_RWEL: rwel_q <= 1'b1;
          OP_COMMIT:   stage_q <= apply_b;
          default:     ;
        endcase
      end
      if (prot_clr) begin
        rwel_q <= 1'b0;
      end
    end
  end

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(cfg_q));
  p_commit_end_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> (!rwel_q && wel_q));
  p_rwel_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rwel_q) |-> (wel_q && $past(apply_v)));
  p_prot_clears_r11: assert property (@(posedge clk) disable iff (rst)
    prot_clr |=> !rwel_q);

endmodule

// File: rtl/prot_ctlreg_seq.sv
module prot_ctlreg_seq
  import ctlreg_pkg::*;
#(
  parameter int         POS_W         = 4,
  parameter int         COMMIT_CYCLES = 1000000,
  parameter logic [7:0] RESET_IMAGE   = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic             txn_stop,
  input  logic             rd_strobe,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic [POS_W-1:0] byte_pos,
  input  logic             byte_to_reg,
  input  logic             byte_prot,
  output logic             byte_ack,
  output logic             byte_nack,
  output logic             busy,
  output logic             wel_o,
  output logic             rwel_o,
  output logic [1:0]       wd_sel,
  output logic [1:0]       pup_sel,
  output logic             bp_en
);

  logic       apply_v;
  logic [7:0] apply_b;
  logic       prot_clr;
  logic       commit_go;
  logic       done;
  logic       wel_q;
  logic       rwel_q;
  cfg_t       cfg_q;

  ctlreg_txn #(.POS_W(POS_W)) u_txn (
    .clk        (clk),
    .rst        (rst),
    .txn_start  (txn_start),
    .txn_stop   (txn_stop),
    .rd_strobe  (rd_strobe),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_pos   (byte_pos),
    .byte_to_reg(byte_to_reg),
    .byte_prot  (byte_prot),
    .wel        (wel_q),
    .busy       (busy),
    .byte_ack   (byte_ack),
    .byte_nack  (byte_nack),
    .apply_v    (apply_v),
    .apply_b    (apply_b),
    .prot_clr   (prot_clr)
  );

  ctlreg_latches #(.RESET_IMAGE(RESET_IMAGE)) u_latches (
    .clk      (clk),
    .rst      (rst),
    .apply_v  (apply_v),
    .apply_b  (apply_b),
    .prot_clr (prot_clr),
    .done     (done),
    .commit_go(commit_go),
    .wel_q    (wel_q),
    .rwel_q   (rwel_q),
    .cfg_q    (cfg_q)
  );

  ctlreg_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(commit_go),
    .busy (busy),
    .done (done)
  );

  assign wel_o   = wel_q;
  assign rwel_o  = rwel_q;
  assign wd_sel  = cfg_q.wd;
  assign pup_sel = cfg_q.pup;
  assign bp_en   = cfg_q.bp;

endmodule

// File: tb/prot_ctlreg_seq_tb.sv
module prot_ctlreg_seq_tb;

  localparam int POS_W = 4;
  localparam int CYC   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn_start = 1'b0, txn_stop = 1'b0, rd_strobe = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic [POS_W-1:0] byte_pos = '0;
  logic byte_to_reg = 1'b0, byte_prot = 1'b0;
  logic byte_ack, byte_nack, busy, wel_o, rwel_o, bp_en;
  logic [1:0] wd_sel, pup_sel;

  int vecs = 0;
  int miss = 0;
  bit finished = 1'b0;

  bit exp_wel = 0, exp_rwel = 0, exp_bp = 0;
  logic [1:0] exp_wd = 0, exp_pup = 0;

  always #2 clk = ~clk;

  prot_ctlreg_seq #(.POS_W(POS_W), .COMMIT_CYCLES(CYC), .RESET_IMAGE(8'h00)) u_dut (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
    .rd_strobe(rd_strobe), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_pos(byte_pos), .byte_to_reg(byte_to_reg), .byte_prot(byte_prot),
    .byte_ack(byte_ack), .byte_nack(byte_nack), .busy(busy), .wel_o(wel_o),
    .rwel_o(rwel_o), .wd_sel(wd_sel), .pup_sel(pup_sel), .bp_en(bp_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk(req, "wel", int'(wel_o), int'(exp_wel));
    chk(req, "rwel", int'(rwel_o), int'(exp_rwel));
    chk(req, "wd", int'(wd_sel), int'(exp_wd));
    chk(req, "pup", int'(pup_sel), int'(exp_pup));
    chk(req, "bp", int'(bp_en), int'(exp_bp));
  endtask

  task automatic do_start();
    txn_start = 1'b1; cyc(); txn_start = 1'b0;
  endtask

  task automatic do_stop();
    txn_stop = 1'b1; cyc(); txn_stop = 1'b0;
    chk("R12", "no response when idle", int'(byte_ack || byte_nack), 0);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1; cyc(); rd_strobe = 1'b0; cyc();
  endtask

  task automatic send(input logic [7:0] b, input bit to_reg, input bit prot, input int pos,
                      output bit a, output bit n);
    byte_valid = 1'b1; byte_data = b; byte_to_reg = to_reg; byte_prot = prot;
    byte_pos = POS_W'(pos);
    cyc();
    a = byte_ack; n = byte_nack;
    byte_valid = 1'b0; byte_prot = 1'b0;
    chk("R12", "ack/nack exclusive", int'(a ^ n), 1);
  endtask

  task automatic wait_commit(input logic [7:0] b);
    int cnt = 0;
    while (busy && cnt < 100) begin cnt++; cyc(); end
    chk("R5", "busy cycles", cnt, CYC);
    exp_pup = {b[7], b[0]}; exp_wd = b[6:5]; exp_bp = b[4]; exp_rwel = 0;
  endtask

  task automatic reg_write(input logic [7:0] b, input string req);
    bit a, n, ea, commit;
    ea = exp_wel || (b == 8'h02);
    commit = 0;
    do_start();
    send(b, 1, 0, 0, a, n);
    chk(req, "reg ack", int'(a), int'(ea));
    do_stop();
    if (ea) begin
      if (b == 8'h00) exp_wel = 0;
      else if (!exp_wel) exp_wel = 1;
      else if (!exp_rwel) begin if (b == 8'h06) exp_rwel = 1; end
      else if (b[3:1] == 3'b001) commit = 1;
    end
    if (commit) wait_commit(b);
    else chk("R3", "no busy", int'(busy), 0);
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vecs++; miss++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    bit a, n;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "ack", int'(byte_ack), 0);
    chk("R1", "nack", int'(byte_nack), 0);
    check_state("R1");

    // R2: every byte with the write-enable latch clear
    for (int i = 0; i < 256; i++) begin
      reg_write(i[7:0], "R2");
      if (exp_wel) reg_write(8'h00, "R3");
    end
    do_start(); send(8'h5A, 0, 0, 0, a, n); do_stop();
    chk("R2", "array byte nack", int'(n), 1);

    // R5/R6/R7: exhaustive third-step byte
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b = i[7:0];
      reg_write(8'h02, "R3");
      reg_write(8'h06, "R4");
      if (b[3:1] == 3'b001) reg_write(b, "R5");
      else if (b[3:1] == 3'b011) reg_write(b, "R6");
      else reg_write(b, "R7");
    end

    // 02,06,F3 then 02,06,06 (unchanged) then 02,06,02 (zeros)
    reg_write(8'h02, "R3"); reg_write(8'h06, "R4"); reg_write(8'hF3, "R5");
    reg_write(8'h02, "R3"); reg_write(8'h06, "R4"); reg_write(8'h06, "R6");
    chk("R6", "rwel kept", int'(rwel_o), 1);
    reg_write(8'h02, "R5");
    chk("R5", "zero image wd", int'(wd_sel), 0);

    // R8: second byte aborts
    reg_write(8'h02, "R3"); reg_write(8'h06, "R4");
    do_start();
    send(8'hF3, 1, 0, 0, a, n); chk("R8", "first byte ack", int'(a), 1);
    send(8'h55, 1, 0, 1, a, n); chk("R8", "second byte nack", int'(n), 1);
    do_stop();
    chk("R8", "no busy", int'(busy), 0);
    check_state("R8");

    // R9: bytes during commit are refused
    do_start(); send(8'hF3, 1, 0, 0, a, n); do_stop();
    chk("R9", "busy after stop", int'(busy), 1);
    do_start(); send(8'h00, 1, 0, 0, a, n); do_stop();
    chk("R9", "reg byte nack while busy", int'(n), 1);
    do_start(); send(8'h11, 0, 0, 0, a, n); do_stop();
    chk("R9", "array byte nack while busy", int'(n), 1);
    while (busy) cyc();
    exp_pup = 2'b11; exp_wd = 2'b11; exp_bp = 1; exp_rwel = 0;
    check_state("R9");

    // R10: reads between steps
    reg_write(8'h02, "R3");
    do_read(); check_state("R10");
    reg_write(8'h06, "R4");
    do_read(); check_state("R10");
    reg_write(8'h63, "R10");

    // R11: protected write clears the register-enable latch
    reg_write(8'h02, "R3"); reg_write(8'h06, "R4");
    do_start(); send(8'hAA, 0, 1, 0, a, n); do_stop();
    chk("R11", "protected nack", int'(n), 1);
    exp_rwel = 0;
    check_state("R11");
    do_start(); send(8'hAA, 0, 0, 0, a, n); do_stop();
    chk("R11", "array ack", int'(a), 1);
    reg_write(8'hF3, "R11");
    chk("R11", "no commit without unlock", int'(pup_sel), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule